// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt requests from up to eleven on-chip peripherals and presents a single interrupt line to the processor. Each request pulse sets a sticky bit in a pending-status register. A companion enable register selects which pending bits may reach the processor. The interrupt line is high whenever some bit is both pending and enabled. Software reads both registers over a simple register bus and writes them with 16-bit or 32-bit accesses, where the accessed halves are chosen by byte enables.

An acknowledge is a write to the status register. In the written byte lanes, each pending bit survives only if the written value has a 1 there and the enable register also has a 1 there, so disabled bits are dropped by the same write. Two configuration inputs pin bit 7 (serial link) and bit 9 (audio unit) as pending: once on the first clock after reset, and again just before every acknowledge is applied. The DMA engine's request enters on bit 3. Registers are placed at byte offset 0x070 (status) and 0x074 (enable) within the block's address window.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is asserted, the status and enable registers are zero and `cpu_irq` is low.
- R2: On the first clock edge after reset is released, status bit 7 is set if `cfg_serial_hold` is 1 and status bit 9 is set if `cfg_sound_hold` is 1.
- R3: A 1 on `src_req[i]` at a clock edge sets status bit i. The bit stays set until it is acknowledged. DMA requests use bit 3.
- R4: A write to the status register works only on the bits in lanes whose byte enable is set, with `bus_be[k]` covering data bits 8k+7..8k. For each such bit, the new value is (old OR held bit) AND enable bit AND written bit. The other bits are unchanged.
- R5: If a request and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R6: A write to the enable register replaces the bits in lanes whose byte enable is set. Bits in other lanes keep their value.
- R7: After every clock edge, `cpu_irq` equals the OR over all bits of (status AND enable) as held after that edge. An enable write that uncovers a pending bit therefore raises `cpu_irq` at that same edge.
- R8: A read decodes `bus_addr[11:2]`. Word 0x070 returns the status register, and word 0x074 returns the enable register. Bits 31..11 read as zero, and any other address reads as zero.
- R9: A write to an address that is neither register changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_serial_hold | input | 1 | Holds status bit 7 pending |
| cfg_sound_hold | input | 1 | Holds status bit 9 pending |
| src_req | input | 11 | Peripheral request pulses, one per status bit (bit 3 is DMA) |
| bus_addr | input | 12 | Byte address within the window |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench targets the bit 3 DMA corner: a request and an acknowledge land on that bit in the same cycle. A design that lets the clear win there loses a DMA completion for good.

An acknowledge with all ones in its data still clears pending bits that the enable register has switched off. Held bits 7 and 9 reappear before the AND is taken, so they survive only where they are enabled. A design that applied them after the AND would keep them pending forever.

Halfword writes to the upper lanes must leave both registers alone. An enable write that uncovers a pending bit must raise the interrupt at the edge that stores the write, not one cycle later.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;

  typedef logic [WORD_W-1:0] word_t;

  // Expand byte enables to a per-bit lane select.
  function automatic word_t lane_bits(input logic [LANES-1:0] be);
    word_t sel;
    sel = '0;
    for (int i = 0; i < WORD_W; i++) sel[i] = be[i / LANE_W];
    return sel;
  endfunction

  // Acknowledge: held bits re-asserted first, then gated by enable and data.
  function automatic word_t ack_apply(input word_t cur, input word_t held,
                                      input word_t en, input word_t wd,
                                      input word_t sel);
    return (cur & ~sel) | ((cur | held) & en & wd & sel);
  endfunction

  // Plain lane-wise replace.
  function automatic word_t lane_merge(input word_t cur, input word_t wd,
                                       input word_t sel);
    return (cur & ~sel) | (wd & sel);
  endfunction
endpackage

// File: rtl/ic_status_reg.sv
module ic_status_reg
  import ic_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 11,
  parameter int unsigned SERIAL_BIT = 7,
  parameter int unsigned SOUND_BIT  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_serial,
  input  logic               hold_sound,
  input  logic               ack_wr,
  input  word_t              ack_data,
  input  word_t              lane_sel,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] stat_q,
  output logic [NUM_SRC-1:0] stat_nxt,
  output logic [NUM_SRC-1:0] held_vec,
  output logic               init_q
);
  logic [NUM_SRC-1:0] base;
  logic [NUM_SRC-1:0] after_ack;
  word_t              acked_w;
  logic               unused_ack_hi;

  always_comb begin
    held_vec             = '0;
    held_vec[SERIAL_BIT] = hold_serial;
    held_vec[SOUND_BIT]  = hold_sound;
  end

  assign base      = stat_q | (init_q ? held_vec : '0);
  assign acked_w   = ack_apply(word_t'(base), word_t'(held_vec), word_t'(en_q),
                               ack_data, lane_sel);
  assign after_ack = ack_wr ? acked_w[NUM_SRC-1:0] : base;
  assign stat_nxt  = after_ack | req;   // set wins over clear
  assign unused_ack_hi = ^acked_w[WORD_W-1:NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      init_q <= 1'b1;
    end else begin
      stat_q <= stat_nxt;
      init_q <= 1'b0;
    end
  end

  // R3 / R5: every requested bit is set after the edge, acknowledge or not
  a_r3_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((stat_q & $past(req)) == $past(req)));

  // R4: an acknowledge never creates a pending bit that was neither pending nor held
  a_r4_ack_no_new: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && req == '0) |=>
      ((stat_q & ~($past(stat_q) | $past(held_vec))) == '0));

  // R2: held bits appear on the first edge after reset
  a_r2_hold_at_init: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !ack_wr) |=> ((stat_q & $past(held_vec)) == $past(held_vec)));
endmodule

// File: rtl/ic_enable_reg.sv
module ic_enable_reg
  import ic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  word_t              wr_data,
  input  word_t              lane_sel,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_nxt
);
  word_t merged_w;
  logic  unused_merge_hi;

  assign merged_w = lane_merge(word_t'(en_q), wr_data, lane_sel);
  assign en_nxt   = en_wr ? merged_w[NUM_SRC-1:0] : en_q;
  assign unused_merge_hi = ^merged_w[WORD_W-1:NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  // R6: the enable register only moves on its own write strobe
  a_r6_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
endmodule

// File: rtl/ic_read_mux.sv
module ic_read_mux
  import ic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               sel_stat,
  input  logic               sel_en,
  input  logic [NUM_SRC-1:0] stat_q,
  input  logic [NUM_SRC-1:0] en_q,
  output word_t              rdata
);
  localparam int unsigned PAD_W = WORD_W - NUM_SRC;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        rdata = '0;
        if (sel_stat)    rdata = {{PAD_W{1'b0}}, stat_q};
        else if (sel_en) rdata = {{PAD_W{1'b0}}, en_q};
      end
    end else begin : g_full
      always_comb begin
        rdata = '0;
        if (sel_stat)    rdata = word_t'(stat_q);
        else if (sel_en) rdata = word_t'(en_q);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import ic_pkg::*;
#(
  parameter int unsigned           NUM_SRC    = 11,
  parameter int unsigned           ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]     STAT_OFS   = 12'h070,
  parameter logic [ADDR_W-1:0]     EN_OFS     = 12'h074,
  parameter int unsigned           SERIAL_BIT = 7,
  parameter int unsigned           SOUND_BIT  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_serial_hold,
  input  logic               cfg_sound_hold,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [LANES-1:0]   bus_be,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               cpu_irq
);
  logic               hit_stat, hit_en, ack_wr, en_wr, init_q, irq_q;
  logic [NUM_SRC-1:0] stat_q, stat_nxt, held_vec, en_q, en_nxt;
  word_t              lane_sel;
  logic               unused_addr_lo;

  assign hit_stat = (bus_addr[ADDR_W-1:2] == STAT_OFS[ADDR_W-1:2]);
  assign hit_en   = (bus_addr[ADDR_W-1:2] == EN_OFS[ADDR_W-1:2]);
  assign ack_wr   = bus_we & hit_stat;
  assign en_wr    = bus_we & hit_en;
  assign lane_sel = lane_bits(bus_be);
  assign unused_addr_lo = ^bus_addr[1:0];

  ic_status_reg #(.NUM_SRC(NUM_SRC), .SERIAL_BIT(SERIAL_BIT), .SOUND_BIT(SOUND_BIT)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .hold_serial(cfg_serial_hold), .hold_sound(cfg_sound_hold),
    .ack_wr(ack_wr), .ack_data(bus_wdata), .lane_sel(lane_sel),
    .en_q(en_q), .req(src_req),
    .stat_q(stat_q), .stat_nxt(stat_nxt), .held_vec(held_vec), .init_q(init_q)
  );

  ic_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .wr_data(bus_wdata),
    .lane_sel(lane_sel), .en_q(en_q), .en_nxt(en_nxt)
  );

  ic_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .sel_stat(hit_stat), .sel_en(hit_en), .stat_q(stat_q), .en_q(en_q),
    .rdata(bus_rdata)
  );

  // Registered from next state so an uncovering enable write fires at its own edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_nxt & en_nxt);
  end
  assign cpu_irq = irq_q;

  // R1: registers clear and line quiet under reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (stat_q == '0 && en_q == '0 && !cpu_irq));

  // R7: the line tracks the stored registers after every edge
  a_r7_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == |(stat_q & en_q));

  // R8: unimplemented read bits stay zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[WORD_W-1:NUM_SRC] == '0);

  // R9: stray writes leave both registers alone
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit_stat && !hit_en && src_req == '0 && !init_q) |=>
      ($stable(stat_q) && $stable(en_q)));

  logic unused_held;
  assign unused_held = ^held_vec;
endmodule

// File: tb/tb_irq_mask_ctrl.sv
`timescale 1ns/1ps
module tb_irq_mask_ctrl;
  localparam int N = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs = 1'b0, hb = 1'b0;
  logic [N-1:0] req = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  logic [N-1:0] m_stat = '0, m_en = '0;
  logic         m_init = 1'b1;
  bit           done = 0;

  always #5 clk = ~clk;

  irq_mask_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_serial_hold(hs), .cfg_sound_hold(hb),
    .src_req(req), .bus_addr(addr), .bus_we(we), .bus_be(be),
    .bus_wdata(wd), .bus_rdata(rdata), .cpu_irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] held();
    logic [N-1:0] h = '0;
    h[7] = hs; h[9] = hb;
    return h;
  endfunction

  // Reference: per-bit restatement of R2..R6, R9
  task automatic model_step();
    logic [N-1:0] h = held();
    logic [N-1:0] ns, ne;
    bit at_stat = (addr[11:2] == 10'h01c);
    bit at_en   = (addr[11:2] == 10'h01d);
    for (int i = 0; i < N; i++) begin
      logic s, e;
      bit lane = be[i/8];
      s = m_stat[i] | (m_init & h[i]);
      if (we && at_stat && lane) s = (s | h[i]) & m_en[i] & wd[i];
      s = s | req[i];
      e = m_en[i];
      if (we && at_en && lane) e = wd[i];
      ns[i] = s; ne[i] = e;
    end
    m_stat = ns; m_en = ne; m_init = 1'b0;
  endtask

  // Drive at a negedge, clock once, check the line at the next negedge (R7).
  task automatic tick(input bit w, input logic [11:0] a, input logic [3:0] b,
                      input logic [31:0] d, input logic [N-1:0] r);
    we = w; addr = a; be = b; wd = d; req = r;
    #1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(irq == |(m_stat & m_en), "R7 irq", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
    we = 0; req = '0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    we = 0; req = '0; addr = a;
    #1;
    if (a[11:2] == 10'h01c)      exp = 32'(m_stat);
    else if (a[11:2] == 10'h01d) exp = 32'(m_en);
    else                         exp = '0;
    chk(rdata == exp, tag, rdata, exp);
    tick(0, a, 4'h0, 32'h0, '0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      report();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    hs = 1; hb = 0;
    addr = 12'h070;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdata == 0, "R1 status in reset", rdata, 0);
    addr = 12'h074; #1;
    chk(rdata == 0, "R1 enable in reset", rdata, 0);
    chk(irq == 0, "R1 irq in reset", {31'b0, irq}, 0);
    rst_n = 1;
    // R2: held serial bit appears after the first edge
    tick(0, 12'h070, 0, 0, '0);
    chk(rdata == 32'h080, "R2 held bit7", rdata, 32'h080);
    rd(12'h070, "R2 status read");
    // R3: DMA request on bit 3
    tick(0, 12'h000, 0, 0, 11'h008);
    rd(12'h070, "R3 dma bit set");
    // R7: enabling bit 3 raises irq at once
    tick(1, 12'h074, 4'h3, 32'h008, '0);
    chk(irq == 1, "R7 uncover", {31'b0, irq}, 1);
    // R4: ack with zero data clears everything incl. held-but-disabled bit 7
    tick(1, 12'h070, 4'h3, 32'h0, '0);
    rd(12'h070, "R4 ack zero");
    chk(rdata == 0, "R4 cleared", rdata, 0);
    // R5: request and acknowledge on bit 3 in one cycle
    tick(1, 12'h070, 4'h3, 32'h0, 11'h008);
    rd(12'h070, "R5 set wins");
    chk(m_stat[3] == 1, "R5 model bit3", 32'(m_stat), 32'h8);
    // R6: upper-half write leaves enable alone
    tick(1, 12'h076, 4'hc, 32'hffff_ffff, '0);
    rd(12'h074, "R6 upper half enable");
    // R4: masked-off bits cleared even when written 1
    tick(0, 12'h000, 0, 0, 11'h003);
    tick(1, 12'h074, 4'h1, 32'h002, '0);
    tick(1, 12'h070, 4'hf, 32'hffff_ffff, '0);
    rd(12'h070, "R4 masked-off cleared");
    chk(rdata[1:0] == 2'b10, "R4 bit1 kept bit0 dropped", rdata, 32'h2);
    // R9: stray write
    tick(1, 12'h078, 4'hf, 32'h0, '0);
    rd(12'h070, "R9 status after stray");
    rd(12'h074, "R9 enable after stray");
    // R8: other address reads zero
    rd(12'h000, "R8 other addr");
    // R4 lane: high byte only touches bits 8..10
    tick(0, 12'h000, 0, 0, 11'h7ff);
    tick(1, 12'h074, 4'h3, 32'h7ff, '0);
    tick(1, 12'h070, 4'h2, 32'h0, '0);
    rd(12'h070, "R4 lane1 only");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      int sel = $urandom_range(0, 5);
      a = (sel < 2) ? 12'h070 : (sel < 4) ? 12'h074 : 12'(($urandom_range(0, 63)) * 4);
      if ($urandom_range(0, 9) == 0) hs = ~hs;
      if ($urandom_range(0, 9) == 0) hb = ~hb;
      tick($urandom_range(0, 1), a, 4'($urandom_range(0, 15)), $urandom(),
           ($urandom_range(0, 2) == 0) ? N'($urandom()) : '0);
      rd(12'h070, "R3 R4 R5 random status");
      rd(12'h074, "R6 random enable");
    end
    done = 1;
    report();
  end
endmodule